// File: doc/BRIEF.md
# Parallel NOR Flash Bus Controller

This block sits on the host side of an asynchronous 16-bit NOR flash bus. It takes requests from a synchronous system clock and turns them into bus waveforms. It drives two active-low bank selects, an active-low output enable, an active-low write enable, a 17-bit word address and the 16-bit write data with its own driver enable. Every bus phase lasts a whole number of clock cycles. Each count is the ceiling of a nanosecond minimum divided by `CLK_PERIOD_NS`, and no phase is shorter than one cycle.

A request is accepted with a valid/ready handshake and carries one of three operations: a single read, a single write, or a full program. A program issues three command writes, then the data write to the target, then repeated status reads of the target. On each read it compares bit 7 of both byte lanes with the value written, and ends when both match or when the poll budget `poll_limit` is spent. Address bit 17 picks the bank. The command addresses and data words are parameters.

The state machine has seven states:
- `S_IDLE` waits for a request. It goes to `S_WR_SETUP` for a write or program, or to `S_RD_ACC` for a read.
- `S_WR_SETUP` lasts one cycle with the strobes set up, then goes to `S_WR_LOW`.
- `S_WR_LOW` holds write enable low, then goes to `S_WR_HIGH`.
- `S_WR_HIGH` either starts the next write of the sequence in `S_WR_SETUP`, starts polling in `S_RD_ACC`, or finishes in `S_DONE`.
- `S_RD_ACC` holds output enable low for the access time, then goes to `S_RD_REC`.
- `S_RD_REC` lets the bus float. It then goes to `S_DONE`, or back to `S_RD_ACC` for another poll.
- `S_DONE` presents the response for one cycle and returns to `S_IDLE`.

Top module: `nor_bus_ctrl`

## Requirements
- R1: After reset both bank selects, output enable and write enable are high, the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: With the default parameters, a read holds the selected bank and output enable low for exactly 6 clock cycles with the address at `req_addr[16:0]`. The response carries the bus value sampled in the last of those cycles. Operation code 0 and code 3 are reads.
- R3: `req_addr[17]`=0 drives `f_cs_n`=2'b10 and `req_addr[17]`=1 drives `f_cs_n`=2'b01. Both bits are never low together.
- R4: A write (code 1) is one setup cycle, then write enable low for exactly 3 cycles, then write enable high for 2 cycles, all with the bank selected and output enable high. Address and data do not change while write enable is low.
- R5: The data driver is enabled only while a bank is selected and output enable is high.
- R6: A program (code 2) issues four writes in one bank, in this order: (0x555, 0xAAAA), (0x2AA, 0x5555), (0x555, 0xA0A0), then (target address, target data).
- R7: After the fourth write, the target is read repeatedly until bits 7 and 15 of the read equal those of the written data. The response then has timeout 0 and carries that read value.
- R8: If `poll_limit` polls all mismatch, the response has `rsp_timeout`=1 and the bus returns to idle with every strobe high. A limit of 0 acts as 1.
- R9: `req_ready` is 1 only in idle, and `rsp_valid` lasts exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0/3 read, 1 write, 2 program |
| req_addr | input | 18 | Word address, bit 17 selects the bank |
| req_data | input | 16 | Write or program data |
| poll_limit | input | 32 | Maximum number of status polls |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Read data or final poll value |
| rsp_timeout | output | 1 | Polling gave up; meaningful with rsp_valid |
| f_cs_n | output | 2 | Active-low bank selects, lower in bit 0 |
| f_oe_n | output | 1 | Active-low output enable |
| f_we_n | output | 1 | Active-low write enable |
| f_addr | output | 17 | Flash word address |
| f_dq_out | output | 16 | Write data toward the flash |
| f_dq_oe | output | 1 | Enable for the host data drivers |
| f_dq_in | input | 16 | Data returned by the flash |

## Verification
The assertions assume a few things about the inputs. `req_op`, `req_addr` and `req_data` only need to be stable in the cycle the handshake completes. `f_dq_in` is assumed to behave like a flash that holds its output steady while output enable is low. The bench flash model meets both conditions: it changes its read value only at falling clock edges, and it ends a busy period only after a complete status read. The stimulus holds `req_valid` for exactly one accepted cycle and always waits for the previous response before it issues another request.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_PROGRAM = 2'd2,
        OP_READ_B  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SETUP,
        S_WR_LOW,
        S_WR_HIGH,
        S_RD_ACC,
        S_RD_REC,
        S_DONE
    } state_e;

    // Round a nanosecond minimum up to whole clock periods.
    function automatic int cyc_of(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nbc_phase_timer.sv
module nbc_phase_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          last
);
    logic [TW-1:0] cnt;

    // Loaded on the state transition; the phase lasts len cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (start)     cnt <= len - TW'(1);
        else if (cnt != '0) cnt <= cnt - TW'(1);
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/nbc_bank_sel.sv
module nbc_bank_sel #(
    parameter int BANKS = 2
) (
    input  logic                     active,
    input  logic [$clog2(BANKS)-1:0] bank,
    output logic [BANKS-1:0]         cs_n
);
    for (genvar b = 0; b < BANKS; b++) begin : g_cs
        assign cs_n[b] = !(active && (bank == b));
    end
endmodule

// File: rtl/nor_bus_ctrl.sv
module nor_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WC_NS   = 60,
    parameter int T_WP_NS   = 30,
    parameter int T_WPH_NS  = 20,
    parameter int T_DS_NS   = 30,
    parameter int T_AH_NS   = 45,
    parameter int T_ACC_NS  = 60,
    parameter int T_OE_NS   = 30,
    parameter int T_DF_NS   = 20,
    parameter int T_OEH_NS  = 10,
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int POLL_W    = 32,
    parameter logic [ADDR_W-2:0] CMD1_ADDR = 'h555,
    parameter logic [DATA_W-1:0] CMD1_DATA = 'hAAAA,
    parameter logic [ADDR_W-2:0] CMD2_ADDR = 'h2AA,
    parameter logic [DATA_W-1:0] CMD2_DATA = 'h5555,
    parameter logic [ADDR_W-2:0] CMD3_ADDR = 'h555,
    parameter logic [DATA_W-1:0] CMD3_DATA = 'hA0A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_timeout,
    output logic [1:0]        f_cs_n,
    output logic              f_oe_n,
    output logic              f_we_n,
    output logic [ADDR_W-2:0] f_addr,
    output logic [DATA_W-1:0] f_dq_out,
    output logic              f_dq_oe,
    input  logic [DATA_W-1:0] f_dq_in
);
    localparam int FA_W    = ADDR_W - 1;
    localparam int LANES   = DATA_W / 8;
    localparam int CYC_SU  = 1;
    localparam int CYC_WP  = imax(imax(cyc_of(T_WP_NS, CLK_PERIOD_NS),
                                       cyc_of(T_DS_NS, CLK_PERIOD_NS)), 1);
    localparam int CYC_WH  = imax(imax(cyc_of(T_WPH_NS, CLK_PERIOD_NS),
                                       cyc_of(T_WC_NS, CLK_PERIOD_NS) - CYC_SU - CYC_WP),
                                  imax(cyc_of(T_AH_NS, CLK_PERIOD_NS) - CYC_WP, 1));
    localparam int CYC_ACC = imax(imax(cyc_of(T_ACC_NS, CLK_PERIOD_NS),
                                       cyc_of(T_OE_NS, CLK_PERIOD_NS)), 1);
    localparam int CYC_REC = imax(imax(cyc_of(T_DF_NS, CLK_PERIOD_NS),
                                       cyc_of(T_OEH_NS, CLK_PERIOD_NS)), 1);
    localparam int CYC_MAX = imax(imax(CYC_WP, CYC_WH), imax(CYC_ACC, CYC_REC));
    localparam int TW      = $clog2(CYC_MAX + 1);

    // Status bit 7 of every byte lane.
    function automatic logic [DATA_W-1:0] poll_mask();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < LANES; i++) m[8*i+7] = 1'b1;
        return m;
    endfunction
    localparam logic [DATA_W-1:0] POLL_MASK = poll_mask();

    state_e            state, state_nx;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rd_q;
    logic [1:0]        step_q;
    logic [POLL_W-1:0] poll_q;
    logic              tmo_q;
    logic              t_start, t_last;
    logic [TW-1:0]     t_len;
    logic              is_prog, is_write, poll_ok, poll_spent, bus_active;

    assign is_prog    = (op_q == OP_PROGRAM);
    assign is_write   = (op_q == OP_WRITE);
    assign poll_ok    = (((rd_q ^ data_q) & POLL_MASK) == '0);
    assign poll_spent = ({1'b0, poll_q} + 1'b1) >= {1'b0, poll_limit};

    nbc_phase_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .len   (t_len),
        .last  (t_last)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Request, sequence and poll registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_READ;
            addr_q <= '0;
            data_q <= '0;
            rd_q   <= '0;
            step_q <= '0;
            poll_q <= '0;
            tmo_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    data_q <= req_data;
                    step_q <= (req_op == OP_PROGRAM) ? 2'd0 : 2'd3;
                    poll_q <= '0;
                    tmo_q  <= 1'b0;
                end
                S_WR_HIGH: if (t_last && step_q != 2'd3) step_q <= step_q + 2'd1;
                S_RD_ACC:  if (t_last) rd_q <= f_dq_in;
                S_RD_REC:  if (t_last && is_prog && !poll_ok) begin
                    poll_q <= poll_q + 1'b1;
                    if (poll_spent) tmo_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Next-state and phase length.
    always_comb begin
        state_nx = state;
        t_start  = 1'b0;
        t_len    = TW'(1);
        unique case (state)
            S_IDLE: if (req_valid) begin
                t_start = 1'b1;
                if (req_op == OP_WRITE || req_op == OP_PROGRAM) begin
                    state_nx = S_WR_SETUP; t_len = TW'(CYC_SU);
                end else begin
                    state_nx = S_RD_ACC;   t_len = TW'(CYC_ACC);
                end
            end
            S_WR_SETUP: if (t_last) begin
                state_nx = S_WR_LOW; t_start = 1'b1; t_len = TW'(CYC_WP);
            end
            S_WR_LOW: if (t_last) begin
                state_nx = S_WR_HIGH; t_start = 1'b1; t_len = TW'(CYC_WH);
            end
            S_WR_HIGH: if (t_last) begin
                if (step_q != 2'd3) begin
                    state_nx = S_WR_SETUP; t_start = 1'b1; t_len = TW'(CYC_SU);
                end else if (is_prog) begin
                    state_nx = S_RD_ACC;   t_start = 1'b1; t_len = TW'(CYC_ACC);
                end else begin
                    state_nx = S_DONE;
                end
            end
            S_RD_ACC: if (t_last) begin
                state_nx = S_RD_REC; t_start = 1'b1; t_len = TW'(CYC_REC);
            end
            S_RD_REC: if (t_last) begin
                if (!is_prog || poll_ok || poll_spent) state_nx = S_DONE;
                else begin
                    state_nx = S_RD_ACC; t_start = 1'b1; t_len = TW'(CYC_ACC);
                end
            end
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        bus_active = 1'b0;
        f_we_n     = 1'b1;
        f_oe_n     = 1'b1;
        f_dq_oe    = 1'b0;
        f_addr     = addr_q[FA_W-1:0];
        f_dq_out   = data_q;
        if (is_prog) begin
            unique case (step_q)
                2'd0: begin f_addr = CMD1_ADDR; f_dq_out = CMD1_DATA; end
                2'd1: begin f_addr = CMD2_ADDR; f_dq_out = CMD2_DATA; end
                2'd2: begin f_addr = CMD3_ADDR; f_dq_out = CMD3_DATA; end
                default: ;
            endcase
        end
        unique case (state)
            S_WR_SETUP, S_WR_HIGH: begin bus_active = 1'b1; f_dq_oe = 1'b1; end
            S_WR_LOW: begin bus_active = 1'b1; f_dq_oe = 1'b1; f_we_n = 1'b0; end
            S_RD_ACC: begin bus_active = 1'b1; f_oe_n = 1'b0; end
            default: ;
        endcase
    end

    nbc_bank_sel #(.BANKS(2)) u_bank (
        .active (bus_active),
        .bank   (addr_q[ADDR_W-1]),
        .cs_n   (f_cs_n)
    );

    assign req_ready   = (state == S_IDLE);
    assign rsp_valid   = (state == S_DONE);
    assign rsp_data    = rd_q;
    assign rsp_timeout = tmo_q && !is_write;
endmodule

// File: rtl/nbc_checks.sv
module nbc_checks #(
    parameter int WP_MIN = 3,
    parameter int FA_W   = 17,
    parameter int DW     = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      f_cs_n,
    input logic            f_oe_n,
    input logic            f_we_n,
    input logic            f_dq_oe,
    input logic [FA_W-1:0] f_addr,
    input logic [DW-1:0]   f_dq_out,
    input logic            req_ready,
    input logic            rsp_valid
);
    int we_lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)       we_lo_cnt <= 0;
        else if (!f_we_n) we_lo_cnt <= we_lo_cnt + 1;
        else              we_lo_cnt <= 0;
    end

    a_r3_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        f_cs_n != 2'b00);

    a_r5_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        f_dq_oe |-> (f_oe_n && f_cs_n != 2'b11));

    a_r4_we_low_context: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> (f_oe_n && f_dq_oe && f_cs_n != 2'b11));

    a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(f_dq_out)));

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_we_n) |-> (we_lo_cnt >= WP_MIN));

    a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (f_cs_n == 2'b11 && f_we_n && f_oe_n && !f_dq_oe));
endmodule

bind nor_bus_ctrl nbc_checks #(.WP_MIN(CYC_WP), .FA_W(ADDR_W-1), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_cs_n    (f_cs_n),
    .f_oe_n    (f_oe_n),
    .f_we_n    (f_we_n),
    .f_dq_oe   (f_dq_oe),
    .f_addr    (f_addr),
    .f_dq_out  (f_dq_out),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/nor_bus_ctrl_tb.sv
module nor_bus_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [31:0] poll_limit = 32'd8;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rsp_timeout;
    logic [1:0]  f_cs_n;
    logic        f_oe_n, f_we_n, f_dq_oe;
    logic [16:0] f_addr;
    logic [15:0] f_dq_out;
    logic [15:0] f_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .poll_limit(poll_limit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_timeout(rsp_timeout), .f_cs_n(f_cs_n), .f_oe_n(f_oe_n),
        .f_we_n(f_we_n), .f_addr(f_addr), .f_dq_out(f_dq_out),
        .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in)
    );

    int total = 0, bad = 0;

    // ---------------- flash model (updated away from the active edge) -------
    int          busy_cfg = 0;
    int          busy_left, cmd, wr_n, rd_n, we_cnt, oe_cnt, viol, rd_w;
    logic        prog_active, we_prev, oe_prev;
    logic [15:0] prog_data;
    logic [1:0]  rd_cs;
    logic [16:0] wr_a [16];
    logic [15:0] wr_d [16];
    logic [1:0]  wr_c [16];
    int          wr_w [16];

    function automatic logic [15:0] mdl(input logic [16:0] a, input logic upper);
        return a[15:0] ^ (upper ? 16'h0F0F : 16'hA5C3);
    endfunction

    always_comb
        f_dq_in = prog_active ? ((busy_left != 0) ? (prog_data ^ 16'h8080) : prog_data)
                              : mdl(f_addr, f_cs_n == 2'b01);

    always @(negedge clk) begin
        if (!rst_n) begin
            busy_left = 0; cmd = 0; wr_n = 0; rd_n = 0; we_cnt = 0; oe_cnt = 0;
            viol = 0; rd_w = 0; prog_active = 1'b0; we_prev = 1'b1; oe_prev = 1'b1;
            prog_data = '0; rd_cs = 2'b11;
        end else begin
            if (f_dq_oe && (!f_oe_n || f_cs_n == 2'b11)) viol++;
            if (f_cs_n == 2'b00) viol++;
            if (!f_we_n) we_cnt++;
            if (f_we_n && !we_prev) begin
                wr_a[wr_n%16] = f_addr; wr_d[wr_n%16] = f_dq_out;
                wr_c[wr_n%16] = f_cs_n; wr_w[wr_n%16] = we_cnt;
                we_cnt = 0; wr_n++;
                if (cmd == 0 && f_addr == 17'h555 && f_dq_out == 16'hAAAA) cmd = 1;
                else if (cmd == 1 && f_addr == 17'h2AA && f_dq_out == 16'h5555) cmd = 2;
                else if (cmd == 2 && f_addr == 17'h555 && f_dq_out == 16'hA0A0) cmd = 3;
                else if (cmd == 3) begin
                    prog_active = 1'b1; prog_data = f_dq_out; busy_left = busy_cfg; cmd = 0;
                end else cmd = 0;
            end
            if (!f_oe_n) begin oe_cnt++; rd_cs = f_cs_n; end
            if (f_oe_n && !oe_prev) begin
                rd_w = oe_cnt; oe_cnt = 0; rd_n++;
                if (prog_active) begin
                    if (busy_left == 0) prog_active = 1'b0;
                    else busy_left--;
                end
            end
            if (rsp_valid) begin prog_active = 1'b0; cmd = 0; end
            we_prev = f_we_n; oe_prev = f_oe_n;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_waddr(input int i, input logic [17:0] t);
        case (i)
            0: return 17'h555;
            1: return 17'h2AA;
            2: return 17'h555;
            default: return t[16:0];
        endcase
    endfunction

    function automatic logic [15:0] exp_wdata(input int i, input logic [15:0] d);
        case (i)
            0: return 16'hAAAA;
            1: return 16'h5555;
            2: return 16'hA0A0;
            default: return d;
        endcase
    endfunction

    function automatic logic [1:0] exp_cs(input logic [17:0] a);
        return a[17] ? 2'b01 : 2'b10;
    endfunction

    logic [15:0] got_data;
    logic        got_tmo;
    int          wr0, rd0;

    task automatic do_req(input logic [1:0] op, input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wr0 = wr_n; rd0 = rd_n;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid) @(negedge clk);
        got_data = rsp_data; got_tmo = rsp_timeout;
        @(negedge clk);
        check("R9 response one cycle", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic do_read(input logic [1:0] op, input logic [17:0] a);
        do_req(op, a, 16'h0);
        check("R2 read data", {16'd0, got_data}, {16'd0, mdl(a[16:0], a[17])});
        check("R2 one bus read", rd_n - rd0, 1);
        check("R2 oe low width", rd_w, 6);
        check("R3 read bank select", {30'd0, rd_cs}, {30'd0, exp_cs(a)});
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d);
        do_req(2'd1, a, d);
        check("R4 one bus write", wr_n - wr0, 1);
        check("R4 write address", {15'd0, wr_a[wr0%16]}, {15'd0, a[16:0]});
        check("R4 write data", {16'd0, wr_d[wr0%16]}, {16'd0, d});
        check("R3 write bank select", {30'd0, wr_c[wr0%16]}, {30'd0, exp_cs(a)});
        check("R4 we low width", wr_w[wr0%16], 3);
    endtask

    task automatic do_prog(input logic [17:0] a, input logic [15:0] d, input int busy,
                           input int limit);
        busy_cfg = busy; poll_limit = limit;
        do_req(2'd2, a, d);
        check("R6 four writes", wr_n - wr0, 4);
        for (int i = 0; i < 4; i++) begin
            check("R6 sequence address", {15'd0, wr_a[(wr0+i)%16]}, {15'd0, exp_waddr(i, a)});
            check("R6 sequence data", {16'd0, wr_d[(wr0+i)%16]}, {16'd0, exp_wdata(i, d)});
            check("R3 sequence bank", {30'd0, wr_c[(wr0+i)%16]}, {30'd0, exp_cs(a)});
        end
        if (busy < limit) begin
            check("R7 poll count", rd_n - rd0, busy + 1);
            check("R7 no timeout", {31'd0, got_tmo}, 32'd0);
            check("R7 final data", {16'd0, got_data}, {16'd0, d});
        end else begin
            check("R8 poll count", rd_n - rd0, (limit < 1) ? 1 : limit);
            check("R8 timeout flag", {31'd0, got_tmo}, 32'd1);
            check("R8 bus idle", {27'd0, f_cs_n, f_oe_n, f_we_n, f_dq_oe}, {27'd0, 2'b11, 1'b1, 1'b1, 1'b0});
        end
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {26'd0, req_ready, rsp_valid, f_cs_n, f_oe_n, f_we_n, f_dq_oe},
              {26'd0, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0});
        do_read(2'd0, 18'h01234);
        do_read(2'd3, 18'h2ABCD);
        do_write(18'h00777, 16'h1234);
        do_write(18'h3FFFF, 16'hFFFF);
        do_prog(18'h21000, 16'h5A3C, 3, 8);
        do_prog(18'h00042, 16'h0080, 0, 1);
        do_prog(18'h10042, 16'h8000, 100, 5);
        do_prog(18'h30000, 16'h1111, 100, 0);
        void'($urandom(32'd20240611));
        for (int k = 0; k < 30; k++) begin
            logic [1:0]  op = 2'($urandom % 3);
            logic [17:0] a  = 18'($urandom);
            logic [15:0] d  = 16'($urandom);
            case (op)
                2'd0:    do_read(2'd0, a);
                2'd1:    do_write(a, d);
                default: do_prog(a, d, int'($urandom % 5), 8);
            endcase
        end
        check("R5 driver and select violations", viol, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule